// File: doc/BRIEF.md
# PCI Data Phase Handshake Tracker

This block sits beside a PCI bus and only listens to it. It watches the cycle frame, initiator ready, target ready, device select and stop lines, and the command/byte-enable nibble. From these it follows each bus transaction. It tells the address phase apart from the data phases that come after it, and it marks each data phase as either a wait clock or a completed transfer.

On every completed transfer the block gives a one-clock strobe. Alongside the strobe it gives the transfer direction, a zero-based index of the transfer within its transaction, and a flag that marks the final transfer. It also shows, combinationally, whether the bus currently carries valid data. Capture logic can use these outputs to take data words off the bus without decoding the handshake itself.

The block also reports when a target asks for the transaction to stop. It records whether any target has claimed the access. It raises a master-abort flag when no target claims the access within a fixed number of clocks.

Top module: `pci_phase_tracker`

## Requirements
- R1: In the idle state, a clock on which `frame_n` is sampled low is the address phase. `addr_phase` is high during that clock, and `bus_active` is high from the next clock on.
- R2: In a data-state clock, `xfer_strobe` is high exactly when `irdy_n` and `trdy_n` are both low. `wait_state` is high on every other data-state clock.
- R3: `xfer_write` is loaded at the address phase from bit 0 of `cbe_n` (1 = write, 0 = read). It holds that value until the next address phase.
- R4: During the data state, `data_valid` equals `!trdy_n` for a read and `!irdy_n` for a write.
- R5: `xfer_index` is 0 for the first completed transfer of a transaction. It rises by one after each completed transfer, wrapping at 2^IDX_W.
- R6: `xfer_last` is high together with `xfer_strobe` when `frame_n` is high. `bus_active` is low on the next clock.
- R7: In the data state, a clock with `frame_n` and `irdy_n` both high returns the tracker to idle on the next clock.
- R8: `stop_req` is high on a data-state clock exactly when `stop_n` is low.
- R9: `claimed` goes high on the clock after `devsel_n` is first sampled low in the data state. It is cleared by the next address phase.
- R10: If `devsel_n` is high on each of the first ABORT_CLKS (default 5) data-state clocks, `master_abort` rises on the following clock. It then holds until the next address phase. It never rises once `claimed` is set.
- R11: Outside the data state, `xfer_strobe`, `wait_state`, `data_valid` and `stop_req` stay low whatever `irdy_n`, `trdy_n` and `stop_n` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| stop_n | input | 1 | Target stop request, active low |
| cbe_n | input | 4 | Command / byte enables; bit 0 gives the direction |
| bus_active | output | 1 | Tracker is in the data state |
| addr_phase | output | 1 | Current clock is an address phase |
| data_valid | output | 1 | Bus carries valid data this clock |
| xfer_strobe | output | 1 | A data phase completes this clock |
| xfer_write | output | 1 | Direction of the current transaction (1 = write) |
| xfer_index | output | IDX_W | Index of the completing transfer |
| xfer_last | output | 1 | Completing transfer is the final one |
| wait_state | output | 1 | Data-state clock without completion |
| stop_req | output | 1 | Target requests stop |
| claimed | output | 1 | A target has claimed the access |
| master_abort | output | 1 | No target claimed within the limit |

## Verification
The assertions assume the bus follows the protocol. In particular, a master does not assert `frame_n` again while the tracker is still in the data state of an earlier transaction. They also assume the inputs change only between clock edges. The stimulus is built from whole transactions that follow these rules: reads, writes, target stops, master aborts, a claim on the last allowed clock and back-to-back cycles. The only protocol-neutral abuse is handshake and stop activity applied while the bus is idle.

// File: rtl/pci_trk_pkg.sv
package pci_trk_pkg;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_DATA = 1'b1
  } trk_state_e;

  // both ready lines low: the transfer is done
  function automatic logic fn_phase_done(input logic irdy_n, input logic trdy_n);
    return !irdy_n && !trdy_n;
  endfunction

  // the side that sources the data flags it
  function automatic logic fn_data_valid(input logic wr, input logic irdy_n,
                                         input logic trdy_n);
    return wr ? !irdy_n : !trdy_n;
  endfunction

  // leave the data state: final transfer done, or master let go of both
  function automatic logic fn_release(input logic frame_n, input logic irdy_n,
                                      input logic trdy_n);
    return frame_n && (irdy_n || fn_phase_done(irdy_n, trdy_n));
  endfunction

  // bit 0 of the command nibble picks write
  function automatic logic fn_cmd_write(input logic [3:0] cbe_n);
    return cbe_n[0];
  endfunction

endpackage

// File: rtl/trk_fsm.sv
module trk_fsm
  import pci_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_n,
  input  logic       irdy_n,
  input  logic       trdy_n,
  input  logic       stop_n,
  input  logic [3:0] cbe_n,
  output logic       bus_active,
  output logic       addr_phase,
  output logic       phase_done,
  output logic       wait_state,
  output logic       last_phase,
  output logic       data_valid,
  output logic       stop_req,
  output logic       is_write
);

  trk_state_e state_q, state_d;
  logic       wr_q;
  logic       release_bus;

  assign bus_active  = (state_q == TRK_DATA);
  assign addr_phase  = (state_q == TRK_IDLE) && !frame_n;
  assign phase_done  = bus_active && fn_phase_done(irdy_n, trdy_n);
  assign wait_state  = bus_active && !phase_done;
  assign last_phase  = phase_done && frame_n;
  assign data_valid  = bus_active && fn_data_valid(wr_q, irdy_n, trdy_n);
  assign stop_req    = bus_active && !stop_n;
  assign release_bus = bus_active && fn_release(frame_n, irdy_n, trdy_n);
  assign is_write    = wr_q;

  always_comb begin
    state_d = state_q;
    if (addr_phase)       state_d = TRK_DATA;
    else if (release_bus) state_d = TRK_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (addr_phase) wr_q <= fn_cmd_write(cbe_n);
    end
  end

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last_phase |=> !bus_active); // R6
  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && $past(bus_active)) |-> $stable(is_write)); // R3
  AST_ENTER_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> bus_active); // R1
  AST_RELEASE_ON_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && frame_n && irdy_n) |=> !bus_active); // R7

endmodule

// File: rtl/trk_count.sv
module trk_count #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic             phase_done,
  output logic [IDX_W-1:0] index
);

  logic [IDX_W-1:0] idx_q;
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  assign index = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx_q <= '0;
    else if (addr_phase) idx_q <= '0;
    else if (phase_done) idx_q <= idx_q + ONE;
  end

  AST_INDEX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |=> (index == '0)); // R5
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && !addr_phase) |=> (index == $past(index) + ONE)); // R5

endmodule

// File: rtl/trk_abort.sv
module trk_abort #(
  parameter int ABORT_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_phase,
  input  logic bus_active,
  input  logic devsel_n,
  output logic claimed,
  output logic master_abort
);

  localparam int CNT_W = $clog2(ABORT_CLKS + 1);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(ABORT_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             claim_q, abort_q;
  logic             watching;

  assign watching     = bus_active && !claim_q && !abort_q;
  assign claimed      = claim_q;
  assign master_abort = abort_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      claim_q <= 1'b0;
      abort_q <= 1'b0;
    end else if (addr_phase) begin
      cnt_q   <= '0;
      claim_q <= 1'b0;
      abort_q <= 1'b0;
    end else if (watching) begin
      if (!devsel_n) begin
        claim_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LIMIT_M1) abort_q <= 1'b1;
      end
    end
  end

  AST_ABORT_UNCLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_abort) |-> !claimed); // R10
  AST_ABORT_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_abort) |-> $past(bus_active)); // R10
  AST_CLAIM_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claimed) |-> $past(!devsel_n && bus_active)); // R9

endmodule

// File: rtl/pci_phase_tracker.sv
module pci_phase_tracker #(
  parameter int IDX_W      = 8,
  parameter int ABORT_CLKS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n,
  input  logic [3:0]       cbe_n,
  output logic             bus_active,
  output logic             addr_phase,
  output logic             data_valid,
  output logic             xfer_strobe,
  output logic             xfer_write,
  output logic [IDX_W-1:0] xfer_index,
  output logic             xfer_last,
  output logic             wait_state,
  output logic             stop_req,
  output logic             claimed,
  output logic             master_abort
);

  logic phase_done;

  trk_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .irdy_n     (irdy_n),
    .trdy_n     (trdy_n),
    .stop_n     (stop_n),
    .cbe_n      (cbe_n),
    .bus_active (bus_active),
    .addr_phase (addr_phase),
    .phase_done (phase_done),
    .wait_state (wait_state),
    .last_phase (xfer_last),
    .data_valid (data_valid),
    .stop_req   (stop_req),
    .is_write   (xfer_write)
  );

  trk_count #(.IDX_W(IDX_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_phase (addr_phase),
    .phase_done (phase_done),
    .index      (xfer_index)
  );

  trk_abort #(.ABORT_CLKS(ABORT_CLKS)) u_abort (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_phase   (addr_phase),
    .bus_active   (bus_active),
    .devsel_n     (devsel_n),
    .claimed      (claimed),
    .master_abort (master_abort)
  );

  assign xfer_strobe = phase_done;

  AST_STROBE_NOT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_strobe && wait_state)); // R2
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_active |-> !(xfer_strobe || wait_state || data_valid || stop_req)); // R11

endmodule

// File: tb/tb_pci_phase_tracker.sv
`timescale 1ns/100ps
module tb_pci_phase_tracker;

  localparam int IDX_W = 8;
  localparam int ABORT_CLKS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;
  logic [3:0] cbe_n = 4'hF;
  logic bus_active, addr_phase, data_valid, xfer_strobe, xfer_write, xfer_last;
  logic wait_state, stop_req, claimed, master_abort;
  logic [IDX_W-1:0] xfer_index;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_run = 1'b0;

  // reference model state
  bit m_active = 0, m_write = 0, m_claimed = 0, m_abort = 0;
  int m_idx = 0, m_cnt = 0;

  always #2.5 clk = ~clk;

  pci_phase_tracker #(.IDX_W(IDX_W), .ABORT_CLKS(ABORT_CLKS)) dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .stop_n(stop_n), .cbe_n(cbe_n),
    .bus_active(bus_active), .addr_phase(addr_phase), .data_valid(data_valid),
    .xfer_strobe(xfer_strobe), .xfer_write(xfer_write), .xfer_index(xfer_index),
    .xfer_last(xfer_last), .wait_state(wait_state), .stop_req(stop_req),
    .claimed(claimed), .master_abort(master_abort)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one bus clock: drive after the falling edge, compare, then advance model at rise
  task automatic step(input bit f, input bit i, input bit t, input bit d, input bit s,
                      input logic [3:0] c);
    bit e_addr, e_done, e_wait, e_last, e_valid, e_stop;
    @(negedge clk);
    frame_n = f; irdy_n = i; trdy_n = t; devsel_n = d; stop_n = s; cbe_n = c;
    #1;
    e_addr  = !m_active && !f;
    e_done  = m_active && !i && !t;
    e_wait  = m_active && !e_done;
    e_last  = e_done && f;
    e_valid = m_active && (m_write ? !i : !t);
    e_stop  = m_active && !s;
    chk("R1", "addr_phase", addr_phase, e_addr);
    chk("R1", "bus_active", bus_active, m_active);
    chk("R2", "xfer_strobe", xfer_strobe, e_done);
    chk("R2", "wait_state", wait_state, e_wait);
    chk("R3", "xfer_write", xfer_write, m_write);
    chk("R4", "data_valid", data_valid, e_valid);
    chk("R5", "xfer_index", xfer_index, m_idx);
    chk("R6", "xfer_last", xfer_last, e_last);
    chk("R8", "stop_req", stop_req, e_stop);
    chk("R9", "claimed", claimed, m_claimed);
    chk("R10", "master_abort", master_abort, m_abort);
    @(posedge clk);
    if (e_addr) begin
      m_active = 1; m_write = c[0]; m_idx = 0; m_claimed = 0; m_cnt = 0; m_abort = 0;
    end else if (m_active) begin
      if (!m_claimed && !m_abort) begin
        if (!d) m_claimed = 1;
        else begin
          m_cnt++;
          if (m_cnt == ABORT_CLKS) m_abort = 1;
        end
      end
      if (e_done) m_idx = (m_idx + 1) % (1 << IDX_W);
      if (f && (e_done || i)) m_active = 0; // R6 / R7
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1, 1, 1, 1, 1, 4'hF);
  endtask

  initial begin : watchdog
    while (!done_run && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done_run) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    // reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "reset bus_active", bus_active, 0);
    chk("R5", "reset xfer_index", xfer_index, 0);
    chk("R10", "reset master_abort", master_abort, 0);
    chk("R9", "reset claimed", claimed, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R11: handshake and stop noise while idle
    step(1, 0, 0, 0, 0, 4'hF);
    step(1, 0, 1, 1, 0, 4'hF);
    idle(1);

    // read burst of three with waits, late claim
    step(0, 1, 1, 1, 1, 4'h6);
    step(0, 0, 1, 1, 1, 4'hF);
    step(0, 0, 1, 0, 1, 4'hF);
    step(0, 0, 0, 0, 1, 4'hF);
    step(0, 0, 1, 0, 1, 4'hF);
    step(0, 0, 0, 0, 1, 4'hF);
    step(1, 0, 0, 0, 1, 4'hF);
    idle(2);

    // single write with a target wait
    step(0, 1, 1, 1, 1, 4'h7);
    step(1, 0, 1, 0, 1, 4'hF);
    step(1, 0, 0, 0, 1, 4'hF);
    idle(1);

    // target stop: disconnect after one transfer (R8, R7)
    step(0, 1, 1, 1, 1, 4'h6);
    step(0, 0, 1, 0, 1, 4'hF);
    step(0, 0, 0, 0, 0, 4'hF);
    step(1, 0, 1, 0, 0, 4'hF);
    step(1, 1, 1, 1, 1, 4'hF);
    idle(1);

    // master abort: nobody claims (R10)
    step(0, 1, 1, 1, 1, 4'h7);
    for (int k = 0; k < 7; k++) step(0, 0, 1, 1, 1, 4'hF);
    step(1, 0, 1, 1, 1, 4'hF);
    step(1, 1, 1, 1, 1, 4'hF);
    idle(2);

    // claim on the last allowed clock: no abort
    step(0, 1, 1, 1, 1, 4'h6);
    for (int k = 0; k < ABORT_CLKS - 1; k++) step(0, 0, 1, 1, 1, 4'hF);
    step(0, 0, 1, 0, 1, 4'hF);
    step(1, 0, 0, 0, 1, 4'hF);
    idle(1);

    // back-to-back: new address phase right after a final transfer
    step(0, 1, 1, 1, 1, 4'h7);
    step(1, 0, 0, 0, 1, 4'hF);
    step(0, 1, 1, 1, 1, 4'h6);
    step(1, 0, 0, 0, 1, 4'hF);
    idle(1);

    // long write burst, index runs up
    step(0, 1, 1, 1, 1, 4'hF);
    for (int k = 0; k < 12; k++) begin
      step(0, 0, 0, 0, 1, 4'hF);
      if (k % 4 == 1) step(0, 1, 0, 0, 1, 4'hF);
    end
    step(1, 0, 0, 0, 1, 4'hF);
    idle(3);

    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule